// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of a byte-wide serial memory reached over SPI in clock modes 0 and 3. The block samples the serial clock, data-in, chip-select and pause pins into the system clock domain. It receives one-byte commands MSB first and collects a 16-bit address. Read data comes out of an internal synchronous array, and the address steps forward on its own. Read-status requests are answered from a byte that the neighbouring status/protection unit supplies. Status and page-program commands are passed on as single-cycle strobes for the units that carry them out.

The data-in bit is taken on each rising edge of the serial clock. The output bit changes on each falling edge. The output enable is a separate pin, so the pad can be tri-stated. The pause pin can stop a transfer in the middle of a byte and continue it later without losing the bit position.

Top module: `spi_mem_frontend`

## Requirements
- R1: While reset is high, and at the first sample after it, `spi_miso_oe` and every command strobe are 0.
- R2: Command codes are 0x06 (enable writes), 0x04 (disable writes), 0x01 (status write, followed by one data byte), 0x05 (status read), 0x03 (array read) and 0x02 (array write). A command that ends when chip select rises gives exactly one strobe: `cmd_wren` for 0x06, `cmd_wrdi` for 0x04, or `cmd_wrsr` for 0x01. At most one strobe is high in any cycle.
- R3: Commands are ignored until the block has seen a falling edge on chip select since reset. Holding chip select low across reset and then clocking a command gives no strobe.
- R4: A status read returns `status_i` MSB first and repeats it for every further byte while chip select stays low. This holds even while `wip_i` is 1.
- R5: An array read takes two address bytes, high byte first. Only the low `ADDR_W` bits are used and the rest are ignored. The first data byte comes from that address. Each later byte comes from the next address, and the count wraps from the top address to 0 for as long as chip select stays low.
- R6: If `wip_i` is 1 when the read command byte completes, the read is rejected. `spi_miso_oe` stays 0 for the rest of that transaction.
- R7: Any unknown command byte makes the block ignore all further bits until chip select rises. The output stays off and no strobe follows.
- R8: A status write or enable/disable command only takes effect if chip select rises on a byte boundary, with no extra rising clock edge after the last byte. If chip select rises in the middle of the status data byte, or after an extra bit, no strobe is given.
- R9: During an array write, each complete data byte gives a `pg_wr` pulse with its address and data. The address starts at the received address. After each byte, only the low `PAGE_W` bits step forward and they wrap within the page. `pg_end` pulses when chip select rises on a byte boundary after at least one data byte.
- R10: A pause starts when the pause pin is low while the serial clock is low. It ends when the pin is high while the serial clock is low. During a pause, clock edges and data-in are ignored and `spi_miso_oe` is 0. After the pause, the transfer carries on at the same bit.
- R11: Raising chip select during a pause ends both the pause and the transaction. The next transaction starts cleanly.
- R12: `spi_miso_oe` is 1 only during the data phase of a status read or an accepted array read. It is 0 in the command and address phases and whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock pin |
| spi_csn | input | 1 | Chip select, active low |
| spi_holdn | input | 1 | Pause request, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| wip_i | input | 1 | Internal write cycle busy |
| status_i | input | 8 | Status byte returned by a status read |
| arr_we | input | 1 | Array write strobe from the page-program unit |
| arr_waddr | input | ADDR_W | Array write address |
| arr_wdata | input | 8 | Array write data |
| cmd_wren | output | 1 | Enable-writes command strobe |
| cmd_wrdi | output | 1 | Disable-writes command strobe |
| cmd_wrsr | output | 1 | Status-write command strobe |
| cmd_wrsr_data | output | 8 | Data byte of the status write |
| pg_wr | output | 1 | Page data byte strobe |
| pg_addr | output | ADDR_W | Address of the page data byte |
| pg_data | output | 8 | Page data byte |
| pg_end | output | 1 | Page program end strobe |

## Verification
The bench builds the block with a 32-byte array (`ADDR_W` = 5) and an 8-byte page (`PAGE_W` = 3). With these sizes, a read that runs past the top address and back to 0 takes only a few bytes, and so does a write that wraps inside a page. The read-address test uses an address whose upper bits are all ones, so the ignored address bits are exercised. Both clock modes are driven, including a pause in the middle of a byte and a chip-select rise during a pause.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_RDAT,
    PH_STAT,
    PH_SRIN,
    PH_WDAT,
    PH_DONE,
    PH_IGNORE
  } phase_e;

  typedef enum logic [1:0] {
    FIN_NONE,
    FIN_WREN,
    FIN_WRDI,
    FIN_WRSR
  } finish_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  // During reset every stage loads the pin value, so release creates no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= din;
      prev <= din;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  always_comb begin
    lvl  = stg[STAGES-1];
    rise = stg[STAGES-1] & ~prev;
    fall = ~stg[STAGES-1] & prev;
  end

endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic holdn_lvl,
  input  logic sclk_lvl,
  output logic holding
);

  // The pause state follows the pin only while the serial clock is low.
  always_ff @(posedge clk) begin
    if (rst) begin
      holding <= 1'b0;
    end else if (!active) begin
      holding <= 1'b0;
    end else if (!sclk_lvl) begin
      holding <= ~holdn_lvl;
    end
  end

endmodule

// File: rtl/spi_rd_array.sv
module spi_rd_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_lvl,
  input  logic              holding,
  input  logic              wip_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rdata,
  output logic              active,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              q_bit,
  output logic              drive,
  output logic              cmd_wren,
  output logic              cmd_wrdi,
  output logic              cmd_wrsr,
  output logic [7:0]        wrsr_data,
  output logic              pg_wr,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              pg_end
);

  localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'((1 << PAGE_W) - 1);

  phase_e            phase;
  finish_e           fin;
  logic              armed;
  logic [2:0]        bitcnt;
  logic [6:0]        sh;
  logic              addr_second;
  logic              is_read;
  logic [7:0]        addr_hi;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        txsh;
  logic              clean;
  logic              wr_any;

  logic              edge_ok;
  logic              byte_done;
  logic [7:0]        in_byte;
  logic [15:0]       full_addr;
  logic [7:0]        src_byte;
  logic [ADDR_W-1:0] page_next;
  logic              unused_addr_hi;

  always_comb begin
    active    = armed & ~csn_lvl;
    edge_ok   = active & ~holding;
    in_byte   = {sh, mosi_lvl};
    byte_done = edge_ok & sclk_rise & (bitcnt == 3'd7);
    full_addr = {addr_hi, in_byte};
    src_byte  = (phase == PH_STAT) ? status_i : mem_rdata;
    page_next = (addr & ~PG_MASK) | ((addr + 1'b1) & PG_MASK);
  end

  assign unused_addr_hi = ^full_addr[15:ADDR_W];
  assign rd_addr        = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      phase       <= PH_IDLE;
      fin         <= FIN_NONE;
      bitcnt      <= '0;
      sh          <= '0;
      addr_second <= 1'b0;
      is_read     <= 1'b0;
      addr_hi     <= '0;
      addr        <= '0;
      txsh        <= '0;
      q_bit       <= 1'b0;
      drive       <= 1'b0;
      clean       <= 1'b0;
      wr_any      <= 1'b0;
      cmd_wren    <= 1'b0;
      cmd_wrdi    <= 1'b0;
      cmd_wrsr    <= 1'b0;
      wrsr_data   <= '0;
      pg_wr       <= 1'b0;
      pg_addr     <= '0;
      pg_data     <= '0;
      pg_end      <= 1'b0;
    end else begin
      cmd_wren <= 1'b0;
      cmd_wrdi <= 1'b0;
      cmd_wrsr <= 1'b0;
      pg_wr    <= 1'b0;
      pg_end   <= 1'b0;
      if (cs_fall) begin
        armed       <= 1'b1;
        phase       <= PH_OPC;
        fin         <= FIN_NONE;
        bitcnt      <= '0;
        addr_second <= 1'b0;
        drive       <= 1'b0;
        clean       <= 1'b1;
        wr_any      <= 1'b0;
      end else if (cs_rise) begin
        if (phase == PH_DONE && clean && bitcnt == 3'd0) begin
          cmd_wren <= (fin == FIN_WREN);
          cmd_wrdi <= (fin == FIN_WRDI);
          cmd_wrsr <= (fin == FIN_WRSR);
        end
        if (phase == PH_WDAT && bitcnt == 3'd0 && wr_any) pg_end <= 1'b1;
        phase <= PH_IDLE;
        drive <= 1'b0;
      end else if (edge_ok && sclk_rise) begin
        sh     <= in_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (phase == PH_DONE) clean <= 1'b0;
        if (bitcnt == 3'd7) begin
          unique case (phase)
            PH_OPC: begin
              unique case (in_byte)
                OP_WREN:  begin phase <= PH_DONE; fin <= FIN_WREN; end
                OP_WRDI:  begin phase <= PH_DONE; fin <= FIN_WRDI; end
                OP_RDSR:  phase <= PH_STAT;
                OP_WRSR:  phase <= PH_SRIN;
                OP_READ:  begin
                  phase   <= wip_i ? PH_IGNORE : PH_ADDR;
                  is_read <= 1'b1;
                end
                OP_WRITE: begin phase <= PH_ADDR; is_read <= 1'b0; end
                default:  phase <= PH_IGNORE;
              endcase
            end
            PH_ADDR: begin
              if (!addr_second) begin
                addr_hi     <= in_byte;
                addr_second <= 1'b1;
              end else begin
                addr  <= full_addr[ADDR_W-1:0];
                phase <= is_read ? PH_RDAT : PH_WDAT;
              end
            end
            PH_RDAT: addr <= addr + 1'b1;
            PH_SRIN: begin
              wrsr_data <= in_byte;
              fin       <= FIN_WRSR;
              phase     <= PH_DONE;
            end
            PH_WDAT: begin
              pg_wr   <= 1'b1;
              pg_addr <= addr;
              pg_data <= in_byte;
              addr    <= page_next;
              wr_any  <= 1'b1;
            end
            default: ;
          endcase
        end
      end else if (edge_ok && sclk_fall && (phase == PH_RDAT || phase == PH_STAT)) begin
        drive <= 1'b1;
        if (bitcnt == 3'd0) begin
          q_bit <= src_byte[7];
          txsh  <= {src_byte[6:0], 1'b0};
        end else begin
          q_bit <= txsh[7];
          txsh  <= {txsh[6:0], 1'b0};
        end
      end
    end
  end

  // R3
  idle_until_armed_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> phase == PH_IDLE);

  // R5
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_RDAT) |=> rd_addr == $past(rd_addr) + 1'b1);

  // R6
  read_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_OPC && in_byte == OP_READ && wip_i) |=> phase == PH_IGNORE);

  // R7
  ignore_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_IGNORE |=> (phase == PH_IGNORE || phase == PH_IDLE));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    holding |=> $stable(bitcnt));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, pg_end}));

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_holdn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              wip_i,
  input  logic [7:0]        status_i,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_waddr,
  input  logic [7:0]        arr_wdata,
  output logic              cmd_wren,
  output logic              cmd_wrdi,
  output logic              cmd_wrsr,
  output logic [7:0]        cmd_wrsr_data,
  output logic              pg_wr,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              pg_end
);

  localparam int NPIN   = 4;
  localparam int P_HOLD = 3;
  localparam int P_CS   = 2;
  localparam int P_CLK  = 1;
  localparam int P_DIN  = 0;

  logic [NPIN-1:0]   pin_lvl, pin_rise, pin_fall;
  logic              active, holding, q_bit, drive;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        mem_rdata;
  logic              unused_edges;

  assign unused_edges = ^{pin_rise[P_HOLD], pin_rise[P_DIN], pin_fall[P_HOLD], pin_fall[P_DIN]};

  spi_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_holdn, spi_csn, spi_sclk, spi_mosi}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  spi_hold_ctl u_hold (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .holdn_lvl (pin_lvl[P_HOLD]),
    .sclk_lvl  (pin_lvl[P_CLK]),
    .holding   (holding)
  );

  spi_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .csn_lvl   (pin_lvl[P_CS]),
    .cs_fall   (pin_fall[P_CS]),
    .cs_rise   (pin_rise[P_CS]),
    .sclk_rise (pin_rise[P_CLK]),
    .sclk_fall (pin_fall[P_CLK]),
    .mosi_lvl  (pin_lvl[P_DIN]),
    .holding   (holding),
    .wip_i     (wip_i),
    .status_i  (status_i),
    .mem_rdata (mem_rdata),
    .active    (active),
    .rd_addr   (rd_addr),
    .q_bit     (q_bit),
    .drive     (drive),
    .cmd_wren  (cmd_wren),
    .cmd_wrdi  (cmd_wrdi),
    .cmd_wrsr  (cmd_wrsr),
    .wrsr_data (cmd_wrsr_data),
    .pg_wr     (pg_wr),
    .pg_addr   (pg_addr),
    .pg_data   (pg_data),
    .pg_end    (pg_end)
  );

  spi_rd_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else begin
      spi_miso    <= q_bit;
      spi_miso_oe <= drive & active & ~holding;
    end
  end

  // R12
  oe_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pin_lvl[P_CS]) |-> !spi_miso_oe);

  // R10
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(holding) |-> !spi_miso_oe);

endmodule

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;

  localparam int AW = 5;
  localparam int PW = 3;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          sclk = 1'b0, csn = 1'b0, holdn = 1'b1, mosi = 1'b0, wip = 1'b0;
  logic [7:0]    status = 8'h00;
  logic          arr_we = 1'b0;
  logic [AW-1:0] arr_waddr = '0;
  logic [7:0]    arr_wdata = 8'h00;
  logic          miso, miso_oe, cmd_wren, cmd_wrdi, cmd_wrsr, pg_wr, pg_end;
  logic [7:0]    cmd_wrsr_data, pg_data;
  logic [AW-1:0] pg_addr;

  spi_mem_frontend #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_holdn(holdn),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .wip_i(wip),
    .status_i(status), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_wrsr_data(cmd_wrsr_data), .pg_wr(pg_wr), .pg_addr(pg_addr),
    .pg_data(pg_data), .pg_end(pg_end)
  );

  int n_run = 0, n_fail = 0;
  int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_pgend = 0;
  logic [7:0] last_wrsr = 8'h00;
  bit mode3 = 1'b0;
  int pg_a_q[$];
  int pg_d_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  task automatic check_eq(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memv(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // strobe monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_wren) n_wren++;
      if (cmd_wrdi) n_wrdi++;
      if (cmd_wrsr) begin n_wrsr++; last_wrsr = cmd_wrsr_data; end
      if (pg_end) n_pgend++;
      if (pg_wr) begin pg_a_q.push_back(int'(pg_addr)); pg_d_q.push_back(int'(pg_data)); end
    end
  end

  // scoreboard monitor: pops received bytes against expected ones
  always @(negedge clk) begin
    if (got_q.size() != 0 && exp_q.size() != 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_eq(t, int'(g), int'(e));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_n(input logic [7:0] tx, input int nb, output logic [7:0] rx, output bit oe_seen);
    rx = 8'h00;
    oe_seen = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = tx[i];
      wait_n(H);
      rx[i] = miso;
      if (miso_oe) oe_seen = 1'b1;
      sclk = 1'b1;
      wait_n(H);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_seen);
    xfer_n(tx, 8, rx, oe_seen);
  endtask

  task automatic send(input logic [7:0] tx, input string tag);
    logic [7:0] rx;
    bit oe;
    xfer(tx, rx, oe);
    check_eq({tag, " oe off while receiving"}, int'(oe), 0);
  endtask

  task automatic expect_rd(input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    bit oe;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(8'h00, rx, oe);
    got_q.push_back(rx);
    check_eq({tag, " oe on"}, int'(oe), 1);
  endtask

  task automatic cs_on();
    @(negedge clk);
    sclk = mode3;
    wait_n(H);
    csn = 1'b0;
    wait_n(H);
  endtask

  task automatic cs_off();
    @(negedge clk);
    if (!mode3) sclk = 1'b0;
    wait_n(H);
    csn = 1'b1;
    wait_n(2 * H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    bit oe;
    int b0;

    // reset with chip select held low
    wait_n(10);
    check_eq("R1 oe in reset", int'(miso_oe), 0);
    check_eq("R1 strobes in reset", int'({cmd_wren, cmd_wrdi, cmd_wrsr, pg_wr, pg_end}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 oe after reset", int'(miso_oe), 0);

    // R3: command before the first chip-select fall is ignored
    send(OP_WREN_c(), "R3");
    cs_off();
    check_eq("R3 no strobe before first cs fall", n_wren, 0);

    // load array through the page-unit port
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      arr_we = 1'b1; arr_waddr = AW'(a); arr_wdata = memv(a);
    end
    @(negedge clk);
    arr_we = 1'b0;

    // R2: enable writes (mode 0), disable writes (mode 3)
    cs_on(); send(8'h06, "R2"); cs_off();
    check_eq("R2 wren strobe", n_wren, 1);
    mode3 = 1'b1;
    cs_on(); send(8'h04, "R2"); cs_off();
    check_eq("R2 wrdi strobe", n_wrdi, 1);
    check_eq("R2 wren unchanged", n_wren, 1);

    // R8: extra bit after enable-writes cancels it
    cs_on(); send(8'h06, "R8"); xfer_n(8'h80, 1, rx, oe); cs_off();
    check_eq("R8 wren with extra bit", n_wren, 1);

    // R4: status read repeats, also while busy (mode 3)
    status = 8'hA6; wip = 1'b1;
    cs_on(); send(8'h05, "R4"); expect_rd(8'hA6, "R4 status byte 1"); expect_rd(8'hA6, "R4 status byte 2"); cs_off();
    mode3 = 1'b0;
    status = 8'h3C;
    cs_on(); send(8'h05, "R4"); expect_rd(8'h3C, "R4 status mode0"); cs_off();
    wip = 1'b0;

    // R5: read with ignored upper address bits and top-to-zero wrap
    cs_on(); send(8'h03, "R12"); send(8'hFF, "R12"); send(8'hFD, "R12");
    expect_rd(memv(29), "R5 first byte");
    expect_rd(memv(30), "R5 next byte");
    expect_rd(memv(31), "R5 top byte");
    expect_rd(memv(0), "R5 wrap to zero");
    expect_rd(memv(1), "R5 after wrap");
    cs_off();
    check_eq("R12 oe off after cs high", int'(miso_oe), 0);

    // R6: read rejected while busy
    wip = 1'b1;
    cs_on(); send(8'h03, "R6"); send(8'h00, "R6"); send(8'h04, "R6");
    xfer(8'h00, rx, oe);
    check_eq("R6 no output while busy", int'(oe), 0);
    cs_off();
    wip = 1'b0;

    // R7: unknown code then a valid code in the same frame
    cs_on(); send(8'hA5, "R7"); send(8'h06, "R7"); send(8'h05, "R7"); cs_off();
    check_eq("R7 no strobe after unknown code", n_wren, 1);

    // R8: status write executes, and is dropped when cs rises mid-byte
    cs_on(); send(8'h01, "R8"); send(8'h8C, "R8"); cs_off();
    check_eq("R8 wrsr strobe", n_wrsr, 1);
    check_eq("R8 wrsr data", int'(last_wrsr), 8'h8C);
    cs_on(); send(8'h01, "R8"); xfer_n(8'hF0, 4, rx, oe); cs_off();
    check_eq("R8 wrsr mid-byte dropped", n_wrsr, 1);

    // R9: page write wraps within an 8-byte page
    cs_on(); send(8'h02, "R9"); send(8'hC0, "R9"); send(8'h0E, "R9");
    send(8'h11, "R9"); send(8'h22, "R9"); send(8'h33, "R9"); cs_off();
    check_eq("R9 page byte count", pg_a_q.size(), 3);
    check_eq("R9 pg_end", n_pgend, 1);
    if (pg_a_q.size() == 3) begin
      check_eq("R9 addr 0", pg_a_q[0], 14);
      check_eq("R9 addr 1", pg_a_q[1], 15);
      check_eq("R9 addr wrap", pg_a_q[2], 8);
      check_eq("R9 data wrap", pg_d_q[2], 8'h33);
    end
    check_eq("R2 wren count unchanged by write", n_wren, 1);

    // R10: pause mid-byte during a read
    cs_on(); send(8'h03, "R10"); send(8'h00, "R10"); send(8'h02, "R10");
    rx = 8'h00;
    for (int i = 7; i >= 4; i--) begin
      @(negedge clk); sclk = 1'b0; mosi = 1'b0; wait_n(H);
      rx[i] = miso;
      if (i > 4) begin sclk = 1'b1; wait_n(H); end
    end
    holdn = 1'b0;
    wait_n(H);
    check_eq("R10 oe off in pause", int'(miso_oe), 0);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; mosi = 1'b1; wait_n(H);
      sclk = 1'b0; wait_n(H);
    end
    check_eq("R10 oe still off", int'(miso_oe), 0);
    holdn = 1'b1;
    wait_n(H);
    check_eq("R10 oe back after pause", int'(miso_oe), 1);
    sclk = 1'b1; wait_n(H);
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; wait_n(H);
      rx[i] = miso;
      sclk = 1'b1; wait_n(H);
    end
    check_eq("R10 byte across pause", int'(rx), int'(memv(2)));
    expect_rd(memv(3), "R10 next byte after pause");
    cs_off();

    // R11: chip select rises during a pause
    cs_on(); send(8'h03, "R11"); send(8'h00, "R11"); xfer_n(8'h00, 2, rx, oe);
    @(negedge clk); sclk = 1'b0; wait_n(H);
    holdn = 1'b0; wait_n(H);
    csn = 1'b1; wait_n(2 * H);
    holdn = 1'b1; wait_n(2 * H);
    check_eq("R11 oe off after abort", int'(miso_oe), 0);
    status = 8'h5A;
    cs_on(); send(8'h05, "R11"); expect_rd(8'h5A, "R11 clean next frame"); cs_off();
    check_eq("R12 oe off when idle", int'(miso_oe), 0);

    b0 = 0;
    while ((exp_q.size() != 0 || got_q.size() != 0) && b0 < 100) begin
      @(negedge clk); b0++;
    end
    check_eq("scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [7:0] OP_WREN_c();
    return 8'h06;
  endfunction

endmodule